// File: doc/BRIEF.md
# ADC result DMA request controller

This block sits between an ADC conversion sequencer and a DMA engine. Each finished regular conversion is written into a result register, and a level DMA request is raised for it. The request is held until the DMA engine acknowledges it. The block detects overrun, which is a new result arriving before the previous one was consumed. It applies a selectable overrun policy and blocks DMA traffic until software clears the overrun flag.

The block has two DMA modes. In circular mode a request follows every new result, whatever the DMA engine reports. In one-shot mode, the transfer-complete indication halts the path. The result register freezes, the conversion in flight is aborted, the scan sequencer is told to restart from its first channel, and later results are ignored until software re-arms the block. An optional auto-delay setting holds back the next regular conversion until the current result is consumed. It holds back the next injected conversion until the injected end-of-sequence flag is cleared.

Every output is registered. All state changes appear one clock after the strobe that causes them.

Top module: `adc_dma_req_ctrl`

## Requirements
- R1: A `conv_done` pulse accepted while the block is not halted loads `conv_data` into `result_data` and sets `eoc_flag`. If `ovr_flag` is clear and no overrun occurs, it also sets `dma_req` one cycle later. `dma_req` stays high until `dma_ack`, and `dma_ack` clears both `dma_req` and `eoc_flag`.
- R2: An overrun is an accepted `conv_done` while `eoc_flag` is 1 and no consume strobe is present in the same cycle. An overrun sets `ovr_flag`, drops `dma_req`, and raises no request for that result. `eoc_flag` stays 1.
- R3: While `ovr_flag` is 1, new results raise no request. `clr_ovr` clears the flag, and the next new result requests again.
- R4: On overrun, `cfg_ovr_overwrite`=0 keeps the old `result_data` and `cfg_ovr_overwrite`=1 loads the new one.
- R5: With `cfg_circular`=1, `dma_tc` has no effect on requests, `dma_halt` or the pulses.
- R6: With `cfg_circular`=0, `dma_tc` sets `dma_halt` and clears `dma_req`. In the same cycle it emits a one-cycle `abort_pulse` and a one-cycle `seq_reset_pulse`, and `reg_start_en` goes low.
- R7: While `dma_halt` is 1, `conv_done` is ignored: `result_data` is frozen, `eoc_flag` is not set and `dma_req` stays low. A further `dma_tc` emits no pulses.
- R8: A `rearm` strobe clears `dma_halt`, and results are accepted and requested again.
- R9: With `cfg_auto_delay`=1, `reg_start_en` is 0 while `eoc_flag` is 1. With `cfg_auto_delay`=0, `reg_start_en` is 1 unless the block is halted.
- R10: `inj_done` sets `jeos_flag` and `clr_jeos` clears it. With `cfg_auto_delay`=1, `inj_start_en` is 0 while `jeos_flag` is 1; otherwise `inj_start_en` is 1.
- R11: Synchronous reset clears `result_data`, all flags, `dma_req` and the pulses, and sets both start enables to 1.
- R12: `eoc_flag` is cleared by `dr_read`, `dma_ack` or `clr_eoc`. Any of these in the same cycle as a new result prevents the overrun, and the new result is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_circular | input | 1 | 1 selects circular mode, 0 selects one-shot mode |
| cfg_ovr_overwrite | input | 1 | 1 overwrites on overrun, 0 keeps the old result |
| cfg_auto_delay | input | 1 | Enables conversion-start gating |
| conv_done | input | 1 | Regular conversion finished (pulse) |
| conv_data | input | DATA_W | Result of the finished conversion |
| inj_done | input | 1 | Injected sequence finished (pulse) |
| dma_ack | input | 1 | DMA engine took the result |
| dma_tc | input | 1 | DMA engine finished its last transfer |
| dr_read | input | 1 | Software read of the result register |
| clr_eoc | input | 1 | Write-one-to-clear of `eoc_flag` |
| clr_ovr | input | 1 | Write-one-to-clear of `ovr_flag` |
| clr_jeos | input | 1 | Write-one-to-clear of `jeos_flag` |
| rearm | input | 1 | Releases the one-shot halt |
| result_data | output | DATA_W | Result register |
| dma_req | output | 1 | Level DMA request |
| reg_start_en | output | 1 | Regular conversion may start |
| inj_start_en | output | 1 | Injected conversion may start |
| abort_pulse | output | 1 | Abort the conversion in flight |
| seq_reset_pulse | output | 1 | Reset the scan sequence to its first channel |
| eoc_flag | output | 1 | Unconsumed result present |
| ovr_flag | output | 1 | Overrun seen |
| jeos_flag | output | 1 | Injected sequence end flag |
| dma_halt | output | 1 | One-shot transfer finished; path halted |

## Verification
A stale `eoc_flag` would show one cycle after the next `conv_done`. A spurious overrun would appear as `ovr_flag` rising with `dma_req` low, and a missed overrun as `dma_req` high with `result_data` changed under the old request. A halt state that is lost or stuck shows within one cycle of `dma_tc` or `rearm`: `result_data` changes under a halt, pulses are missing or repeated, or `reg_start_en` is wrong. The directed vectors cover each of these transitions, including same-cycle consume and new result, and acknowledge together with transfer complete.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;
  typedef enum logic {
    XFER_ONESHOT  = 1'b0,
    XFER_CIRCULAR = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/adc_dr_unit.sv
// Result register, end-of-conversion and overrun tracking.
module adc_dr_unit #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_ovr_overwrite,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              freeze,
  input  logic              consume,
  input  logic              clr_ovr,
  output logic              new_evt,
  output logic              ovr_evt,
  output logic              eoc_next,
  output logic              eoc_q,
  output logic              ovr_q,
  output logic [DATA_W-1:0] data_q
);
  logic accept;
  logic load;

  always_comb begin
    accept  = conv_done & ~freeze;
    ovr_evt = accept & eoc_q & ~consume;
    new_evt = accept & ~ovr_evt;
    load    = new_evt | (ovr_evt & cfg_ovr_overwrite);
    if (accept)       eoc_next = 1'b1;
    else if (consume) eoc_next = 1'b0;
    else              eoc_next = eoc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      eoc_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (load) data_q <= conv_data;
      eoc_q <= eoc_next;
      if (ovr_evt)      ovr_q <= 1'b1;
      else if (clr_ovr) ovr_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_dma_req_unit.sv
// DMA request level, one-shot halt and abort/sequence-reset pulses.
module adc_dma_req_unit
  import adc_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  xfer_mode_e mode,
  input  logic       dma_ack,
  input  logic       dma_tc,
  input  logic       rearm,
  input  logic       new_evt,
  input  logic       ovr_evt,
  input  logic       ovr_q,
  output logic       halt_set,
  output logic       halt_next,
  output logic       req_q,
  output logic       halt_q,
  output logic       abort_q,
  output logic       seqrst_q
);
  logic req_next;

  always_comb begin
    halt_set = dma_tc & (mode == XFER_ONESHOT) & ~halt_q;
    if (halt_set)   halt_next = 1'b1;
    else if (rearm) halt_next = 1'b0;
    else            halt_next = halt_q;

    if (halt_set | ovr_evt)             req_next = 1'b0;
    else if (new_evt & ~ovr_q & ~halt_q) req_next = 1'b1;
    else if (dma_ack)                   req_next = 1'b0;
    else                                req_next = req_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= 1'b0;
      halt_q   <= 1'b0;
      abort_q  <= 1'b0;
      seqrst_q <= 1'b0;
    end else begin
      req_q    <= req_next;
      halt_q   <= halt_next;
      abort_q  <= halt_set;
      seqrst_q <= halt_set;
    end
  end
endmodule

// File: rtl/adc_start_gate.sv
// Auto-delay gating of regular and injected conversion starts.
module adc_start_gate (
  input  logic clk,
  input  logic rst,
  input  logic cfg_auto_delay,
  input  logic eoc_next,
  input  logic halt_next,
  input  logic inj_done,
  input  logic clr_jeos,
  output logic reg_en_q,
  output logic inj_en_q,
  output logic jeos_q
);
  logic jeos_next;

  always_comb begin
    if (inj_done)      jeos_next = 1'b1;
    else if (clr_jeos) jeos_next = 1'b0;
    else               jeos_next = jeos_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      jeos_q   <= 1'b0;
      reg_en_q <= 1'b1;
      inj_en_q <= 1'b1;
    end else begin
      jeos_q   <= jeos_next;
      reg_en_q <= ~halt_next & ~(cfg_auto_delay & eoc_next);
      inj_en_q <= ~(cfg_auto_delay & jeos_next);
    end
  end
endmodule

// File: rtl/adc_dma_req_ctrl.sv
module adc_dma_req_ctrl
  import adc_dma_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_circular,
  input  logic              cfg_ovr_overwrite,
  input  logic              cfg_auto_delay,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              inj_done,
  input  logic              dma_ack,
  input  logic              dma_tc,
  input  logic              dr_read,
  input  logic              clr_eoc,
  input  logic              clr_ovr,
  input  logic              clr_jeos,
  input  logic              rearm,
  output logic [DATA_W-1:0] result_data,
  output logic              dma_req,
  output logic              reg_start_en,
  output logic              inj_start_en,
  output logic              abort_pulse,
  output logic              seq_reset_pulse,
  output logic              eoc_flag,
  output logic              ovr_flag,
  output logic              jeos_flag,
  output logic              dma_halt
);
  xfer_mode_e mode;
  logic new_evt, ovr_evt, eoc_next, halt_set, halt_next, consume;

  assign mode    = cfg_circular ? XFER_CIRCULAR : XFER_ONESHOT;
  assign consume = dr_read | dma_ack | clr_eoc;

  adc_dr_unit #(.DATA_W(DATA_W)) dr_u (
    .clk(clk), .rst(rst),
    .cfg_ovr_overwrite(cfg_ovr_overwrite),
    .conv_done(conv_done), .conv_data(conv_data),
    .freeze(dma_halt | halt_set),
    .consume(consume), .clr_ovr(clr_ovr),
    .new_evt(new_evt), .ovr_evt(ovr_evt), .eoc_next(eoc_next),
    .eoc_q(eoc_flag), .ovr_q(ovr_flag), .data_q(result_data)
  );

  adc_dma_req_unit req_u (
    .clk(clk), .rst(rst), .mode(mode),
    .dma_ack(dma_ack), .dma_tc(dma_tc), .rearm(rearm),
    .new_evt(new_evt), .ovr_evt(ovr_evt), .ovr_q(ovr_flag),
    .halt_set(halt_set), .halt_next(halt_next),
    .req_q(dma_req), .halt_q(dma_halt),
    .abort_q(abort_pulse), .seqrst_q(seq_reset_pulse)
  );

  adc_start_gate gate_u (
    .clk(clk), .rst(rst), .cfg_auto_delay(cfg_auto_delay),
    .eoc_next(eoc_next), .halt_next(halt_next),
    .inj_done(inj_done), .clr_jeos(clr_jeos),
    .reg_en_q(reg_start_en), .inj_en_q(inj_start_en), .jeos_q(jeos_flag)
  );
endmodule

// File: rtl/adc_dma_req_ctrl_chk.sv
module adc_dma_req_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic cfg_auto_delay,
  input logic dma_ack,
  input logic dma_req,
  input logic reg_start_en,
  input logic inj_start_en,
  input logic abort_pulse,
  input logic seq_reset_pulse,
  input logic eoc_flag,
  input logic ovr_flag,
  input logic jeos_flag,
  input logic dma_halt
);
  // R3
  ovr_blocks_req_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_flag |-> !dma_req);
  // R6
  halt_blocks_req_chk: assert property (@(posedge clk) disable iff (rst)
    dma_halt |-> (!dma_req && !reg_start_en));
  // R6
  halt_pulses_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_halt) |-> (abort_pulse && seq_reset_pulse));
  // R7
  no_repeat_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |=> !abort_pulse);
  // R1
  req_drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dma_req) |-> ($past(dma_ack) || ovr_flag || dma_halt));
  // R9
  reg_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_auto_delay) && eoc_flag) |-> !reg_start_en);
  // R10
  inj_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_auto_delay) && jeos_flag) |-> !inj_start_en);
endmodule

bind adc_dma_req_ctrl adc_dma_req_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .cfg_auto_delay(cfg_auto_delay), .dma_ack(dma_ack),
  .dma_req(dma_req), .reg_start_en(reg_start_en), .inj_start_en(inj_start_en),
  .abort_pulse(abort_pulse), .seq_reset_pulse(seq_reset_pulse),
  .eoc_flag(eoc_flag), .ovr_flag(ovr_flag), .jeos_flag(jeos_flag),
  .dma_halt(dma_halt)
);

// File: tb/adc_dma_req_ctrl_tb_top.sv
module adc_dma_req_ctrl_tb_top;
  localparam int DW = 12;
  localparam int NV = 23;
  localparam int VW = 39;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_circular = 0, cfg_ovr_overwrite = 0, cfg_auto_delay = 0;
  logic conv_done = 0, inj_done = 0, dma_ack = 0, dma_tc = 0, dr_read = 0;
  logic clr_eoc = 0, clr_ovr = 0, clr_jeos = 0, rearm = 0;
  logic [DW-1:0] conv_data = '0;
  logic [DW-1:0] result_data;
  logic dma_req, reg_start_en, inj_start_en, abort_pulse, seq_reset_pulse;
  logic eoc_flag, ovr_flag, jeos_flag, dma_halt;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  adc_dma_req_ctrl #(.DATA_W(DW)) dut_i (.*);

  // {circ,ovw,ad}, conv_done, data, {ack,tc,rd,ceoc,covr,rearm},
  // expected {req,eoc,ovr,halt,reg_en}, expected data
  localparam logic [VW-1:0] TBL [NV] = '{
    {3'b100, 1'b1, 12'h111, 6'b000000, 5'b11001, 12'h111},
    {3'b100, 1'b0, 12'h000, 6'b100000, 5'b00001, 12'h111},
    {3'b100, 1'b1, 12'h222, 6'b000000, 5'b11001, 12'h222},
    {3'b100, 1'b1, 12'h333, 6'b000000, 5'b01101, 12'h222},
    {3'b100, 1'b1, 12'h444, 6'b000000, 5'b01101, 12'h222},
    {3'b100, 1'b0, 12'h000, 6'b001000, 5'b00101, 12'h222},
    {3'b100, 1'b1, 12'h555, 6'b000000, 5'b01101, 12'h555},
    {3'b100, 1'b0, 12'h000, 6'b001010, 5'b00001, 12'h555},
    {3'b100, 1'b1, 12'h666, 6'b000000, 5'b11001, 12'h666},
    {3'b100, 1'b1, 12'h6A6, 6'b001000, 5'b11001, 12'h6A6},
    {3'b110, 1'b1, 12'h777, 6'b000000, 5'b01101, 12'h777},
    {3'b110, 1'b0, 12'h000, 6'b000110, 5'b00001, 12'h777},
    {3'b100, 1'b1, 12'h888, 6'b000000, 5'b11001, 12'h888},
    {3'b100, 1'b0, 12'h000, 6'b010000, 5'b11001, 12'h888},
    {3'b100, 1'b0, 12'h000, 6'b100000, 5'b00001, 12'h888},
    {3'b001, 1'b1, 12'h999, 6'b000000, 5'b11000, 12'h999},
    {3'b001, 1'b0, 12'h000, 6'b100000, 5'b00001, 12'h999},
    {3'b001, 1'b1, 12'hAAA, 6'b000000, 5'b11000, 12'hAAA},
    {3'b001, 1'b0, 12'h000, 6'b000100, 5'b10001, 12'hAAA},
    {3'b001, 1'b0, 12'h000, 6'b110000, 5'b00010, 12'hAAA},
    {3'b001, 1'b1, 12'hBBB, 6'b000000, 5'b00010, 12'hAAA},
    {3'b001, 1'b0, 12'h000, 6'b000001, 5'b00001, 12'hAAA},
    {3'b001, 1'b1, 12'hCCC, 6'b000000, 5'b11000, 12'hCCC}
  };
  string row_tag [NV] = '{"R1", "R1", "R1", "R2", "R4", "R12", "R3", "R3",
                          "R3", "R12", "R4", "R12", "R1", "R5", "R1", "R9",
                          "R9", "R9", "R12", "R6", "R7", "R8", "R8"};

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_strobes();
    conv_done = 0; inj_done = 0; dma_ack = 0; dma_tc = 0; dr_read = 0;
    clr_eoc = 0; clr_ovr = 0; clr_jeos = 0; rearm = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    clear_strobes();
  endtask

  function automatic logic [16:0] obs();
    return {dma_req, eoc_flag, ovr_flag, dma_halt, reg_start_en, result_data};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R11: reset state
    check("R11", {inj_start_en, abort_pulse, seq_reset_pulse, jeos_flag, obs()},
          {1'b1, 1'b0, 1'b0, 1'b0, 5'b00001, 12'h000});

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = TBL[i];
      {cfg_circular, cfg_ovr_overwrite, cfg_auto_delay} = v[38:36];
      conv_done = v[35];
      conv_data = v[34:23];
      {dma_ack, dma_tc, dr_read, clr_eoc, clr_ovr, rearm} = v[22:17];
      tick();
      check(row_tag[i], {47'b0, obs()}, {47'b0, v[16:0]});
    end

    // R6: one-shot completion pulses (state: eoc=1, req=1, data CCC)
    dma_tc = 1; tick();
    check("R6", {abort_pulse, seq_reset_pulse, dma_halt, dma_req, reg_start_en},
          5'b11100);
    tick();
    check("R6", {abort_pulse, seq_reset_pulse}, 2'b00);
    // R7: second completion while halted emits no pulse; data frozen
    dma_tc = 1; conv_done = 1; conv_data = 12'h5A5; tick();
    check("R7", {abort_pulse, seq_reset_pulse, dma_halt, result_data},
          {3'b001, 12'hCCC});
    rearm = 1; tick();
    check("R8", {dma_halt}, 1'b0);

    // R10: injected gating with auto-delay on
    cfg_auto_delay = 1; inj_done = 1; tick();
    check("R10", {jeos_flag, inj_start_en}, 2'b10);
    clr_jeos = 1; tick();
    check("R10", {jeos_flag, inj_start_en}, 2'b01);
    // R10: no gating with auto-delay off
    cfg_auto_delay = 0; inj_done = 1; tick();
    check("R10", {jeos_flag, inj_start_en}, 2'b11);
    clr_jeos = 1; tick();

    // R9: auto-delay off keeps regular start enabled with eoc set
    dma_ack = 1; tick();
    conv_done = 1; conv_data = 12'h0F0; tick();
    check("R9", {eoc_flag, reg_start_en}, 2'b11);

    // R11: reset from a busy state
    cfg_ovr_overwrite = 0; conv_done = 1; conv_data = 12'h0F1; tick();
    inj_done = 1; tick();
    rst = 1; tick(); rst = 0;
    check("R11", {inj_start_en, jeos_flag, obs()},
          {1'b1, 1'b0, 5'b00001, 12'h000});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule